// File: doc/BRIEF.md
# Time-Multiplexed Complex Multiplier

This block multiplies a stream of complex samples by complex coefficients, such as the twiddle factors in a pipelined FFT, using one shared real multiplier. The multiplier runs on a clock three times the sample rate. The three real products that a complex product needs are formed on that multiplier in three consecutive cycles. A free-running phase counter divides the fast clock into three-cycle slots. A sample/coefficient pair can enter once per slot, and each result leaves after a fixed latency, so downstream control can be aligned to it.

With sample a + jb and coefficient c + jd, the block forms k1 = c(a+b), k2 = a(d-c) and k3 = b(c+d). The real part of the result is k1 - k3 and the imaginary part is k1 + k2. The pre-adder sums are one bit wider than the operands. The exact result is then truncated to the parameterised output width by dropping low-order bits.

Top module: `tri_product_cmul`

## Requirements
- R1: While rst_n is low, out_valid, out_re and out_im are 0 and in_slot is 1.
- R2: in_slot is high in the first cycle after reset release and then on every third cycle, giving the pattern 1,0,0 repeating.
- R3: Inputs are captured only on a rising edge in a cycle where in_slot and in_valid are both high. Data and in_valid presented in other cycles have no effect on any output.
- R4: With OUT_W equal to DW+CW+1, out_re equals a·c − b·d and out_im equals a·d + b·c exactly, all values two's complement.
- R5: With a smaller OUT_W, each output equals the exact result arithmetically shifted right by DW+CW+1−OUT_W bits, which rounds toward negative infinity.
- R6: The result and a one-cycle out_valid pulse appear on the third rising edge after the capturing edge. out_valid is never high in two adjacent cycles.
- R7: A slot without a capture produces no out_valid pulse. out_re and out_im change only in cycles where out_valid is high and otherwise hold their last value.
- R8: Full-scale negative operands on all four inputs give the exact result with no overflow (real 0, imaginary 2^(DW+CW−1)).
- R9: Captures in consecutive slots give one correct result every three cycles with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, three cycles per sample |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample/coefficient pair present |
| smp_re | input | DW | Sample real part a (signed) |
| smp_im | input | DW | Sample imaginary part b (signed) |
| cof_re | input | CW | Coefficient real part c (signed) |
| cof_im | input | CW | Coefficient imaginary part d (signed) |
| in_slot | output | 1 | High in the cycle whose closing edge may capture inputs |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_re | output | OUT_W | Real part of the product (signed) |
| out_im | output | OUT_W | Imaginary part of the product (signed) |

## Verification
The bench builds two copies with unequal operand widths, DW=12 and CW=10. These unequal widths exercise the sign extension that brings both operands to a common multiplier width. One copy sets OUT_W=23, the full exact width, so every product can be compared bit for bit. The other sets OUT_W=14, which drops nine low bits and checks that truncation rounds toward negative infinity on negative results. Full-scale negative operands reach the one case whose imaginary part needs every bit of the full width. Back-to-back slots, skipped slots and off-slot noise check that the sharing schedule never mixes operands from neighbouring samples.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  // Phase of the three-cycle schedule. The product formed in each phase is in the name.
  // Capture of new operands happens on the edge that closes PH_K3.
  typedef enum logic [1:0] {
    PH_K3 = 2'd0,
    PH_K1 = 2'd1,
    PH_K2 = 2'd2
  } phase_e;

  function automatic phase_e phase_after(input phase_e p);
    case (p)
      PH_K3:   return PH_K1;
      PH_K1:   return PH_K2;
      default: return PH_K3;
    endcase
  endfunction
endpackage

// File: rtl/tpc_phase_seq.sv
module tpc_phase_seq
  import tpc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_e phase_o
);
  phase_e ph_q, ph_d;

  always_comb begin
    ph_d = phase_after(ph_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_K3;
    else        ph_q <= ph_d;
  end

  assign phase_o = ph_q;
endmodule

// File: rtl/tpc_operand_sel.sv
module tpc_operand_sel
  import tpc_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int W  = 17
) (
  input  logic                clk,
  input  logic                rst_n,
  input  phase_e              phase,
  input  logic                load_en,
  input  logic                vld_in,
  input  logic signed [DW-1:0] a_in,
  input  logic signed [DW-1:0] b_in,
  input  logic signed [CW-1:0] c_in,
  input  logic signed [CW-1:0] d_in,
  output logic                vld_o,
  output logic signed [W-1:0] x_o,
  output logic signed [W-1:0] y_o
);
  logic signed [DW-1:0] a_q, b_q, a_d, b_d;
  logic signed [CW-1:0] c_q, d_q, c_d, d_d;
  logic                 v_q, v_d;
  logic signed [W-1:0]  ae, be, ce, de;

  // Next-state: hold unless this is the capture edge.
  always_comb begin
    a_d = a_q; b_d = b_q; c_d = c_q; d_d = d_q; v_d = v_q;
    if (load_en) begin
      a_d = a_in; b_d = b_in; c_d = c_in; d_d = d_in; v_d = vld_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0; b_q <= '0; c_q <= '0; d_q <= '0; v_q <= 1'b0;
    end else begin
      a_q <= a_d; b_q <= b_d; c_q <= c_d; d_q <= d_d; v_q <= v_d;
    end
  end

  // Bring both operand pairs to the common multiplier width.
  assign ae = {{(W-DW){a_q[DW-1]}}, a_q};
  assign be = {{(W-DW){b_q[DW-1]}}, b_q};
  assign ce = {{(W-CW){c_q[CW-1]}}, c_q};
  assign de = {{(W-CW){d_q[CW-1]}}, d_q};

  // Pre-adder and operand steering for the shared multiplier.
  always_comb begin
    case (phase)
      PH_K1:   begin x_o = ae + be; y_o = ce; end
      PH_K2:   begin x_o = de - ce; y_o = ae; end
      default: begin x_o = ce + de; y_o = be; end
    endcase
  end

  assign vld_o = v_q;
endmodule

// File: rtl/tpc_mac.sv
module tpc_mac
  import tpc_pkg::*;
#(
  parameter int W      = 17,
  parameter int FULL_W = 33,
  parameter int OUT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  phase_e                  phase,
  input  logic                    vld,
  input  logic signed [W-1:0]     x,
  input  logic signed [W-1:0]     y,
  output logic                    out_valid_o,
  output logic signed [OUT_W-1:0] re_o,
  output logic signed [OUT_W-1:0] im_o
);
  localparam int SHIFT = FULL_W - OUT_W;

  logic signed [FULL_W-1:0] prod, term, sum;
  logic signed [FULL_W-1:0] acc_q, acc_d, hold_q, hold_d;
  logic signed [OUT_W-1:0]  re_q, re_d, im_q, im_d;
  logic                     ov_q, ov_d;
  logic                     fin;

  // Single real multiplier. Modulo FULL_W arithmetic is exact because every
  // partial and final value fits in FULL_W signed bits.
  assign prod = FULL_W'(x) * FULL_W'(y);
  assign term = (phase == PH_K3) ? -prod : prod;
  assign sum  = acc_q + term;
  assign fin  = (phase == PH_K3) && vld;

  always_comb begin
    acc_d  = (phase == PH_K1) ? prod : acc_q;
    hold_d = (phase == PH_K2) ? sum  : hold_q;
    re_d   = re_q;
    im_d   = im_q;
    if (fin) begin
      re_d = OUT_W'(sum    >>> SHIFT);
      im_d = OUT_W'(hold_q >>> SHIFT);
    end
    ov_d = fin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0; hold_q <= '0; re_q <= '0; im_q <= '0; ov_q <= 1'b0;
    end else begin
      acc_q <= acc_d; hold_q <= hold_d; re_q <= re_d; im_q <= im_d; ov_q <= ov_d;
    end
  end

  assign out_valid_o = ov_q;
  assign re_o        = re_q;
  assign im_o        = im_q;
endmodule

// File: rtl/tri_product_cmul.sv
module tri_product_cmul
  import tpc_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int OUT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [DW-1:0]    smp_re,
  input  logic signed [DW-1:0]    smp_im,
  input  logic signed [CW-1:0]    cof_re,
  input  logic signed [CW-1:0]    cof_im,
  output logic                    in_slot,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_re,
  output logic signed [OUT_W-1:0] out_im
);
  localparam int W      = ((DW > CW) ? DW : CW) + 1;
  localparam int FULL_W = DW + CW + 1;

  phase_e              phase;
  logic                op_vld;
  logic signed [W-1:0] mx, my;

  tpc_phase_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase_o (phase)
  );

  assign in_slot = (phase == PH_K3);

  tpc_operand_sel #(.DW(DW), .CW(CW), .W(W)) u_ops (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase   (phase),
    .load_en (in_slot),
    .vld_in  (in_valid),
    .a_in    (smp_re),
    .b_in    (smp_im),
    .c_in    (cof_re),
    .d_in    (cof_im),
    .vld_o   (op_vld),
    .x_o     (mx),
    .y_o     (my)
  );

  tpc_mac #(.W(W), .FULL_W(FULL_W), .OUT_W(OUT_W)) u_mac (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase       (phase),
    .vld         (op_vld),
    .x           (mx),
    .y           (my),
    .out_valid_o (out_valid),
    .re_o        (out_re),
    .im_o        (out_im)
  );
endmodule

// File: rtl/tri_product_cmul_chk.sv
module tri_product_cmul_chk #(
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_slot,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_re,
  input logic [OUT_W-1:0] out_im
);
  assert_slot_cadence_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_slot |=> !in_slot ##1 !in_slot ##1 in_slot);

  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_pulse_after_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_slot));

  assert_pulse_needs_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && in_slot, 4));

  assert_outputs_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_re) && $stable(out_im)));
endmodule

bind tri_product_cmul tri_product_cmul_chk #(.OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_slot   (in_slot),
  .out_valid (out_valid),
  .out_re    (out_re),
  .out_im    (out_im)
);

// File: tb/tri_product_cmul_test.sv
module tri_product_cmul_test;
  localparam int DW     = 12;
  localparam int CW     = 10;
  localparam int FULL_W = DW + CW + 1;
  localparam int TW     = 14;
  localparam int SH     = FULL_W - TW;

  logic clk, rst_n, in_valid;
  logic signed [DW-1:0] a, b;
  logic signed [CW-1:0] c, d;
  logic in_slot, out_valid, f_slot, f_valid;
  logic signed [TW-1:0]     t_re, t_im;
  logic signed [FULL_W-1:0] f_re, f_im;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  tri_product_cmul #(.DW(DW), .CW(CW), .OUT_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .smp_re(a), .smp_im(b), .cof_re(c), .cof_im(d),
    .in_slot(in_slot), .out_valid(out_valid), .out_re(t_re), .out_im(t_im));

  tri_product_cmul #(.DW(DW), .CW(CW), .OUT_W(FULL_W)) uut_full (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .smp_re(a), .smp_im(b), .cof_re(c), .cof_im(d),
    .in_slot(f_slot), .out_valid(f_valid), .out_re(f_re), .out_im(f_im));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_result(input longint ar, input longint br, input longint cr,
                              input longint dr, input string req);
    longint er, ei;
    er = ar * cr - br * dr;
    ei = ar * dr + br * cr;
    chk(out_valid == 1'b1, {req, " valid pulse"}, out_valid, 1);
    chk(f_valid == 1'b1, {req, " valid pulse full"}, f_valid, 1);
    chk(longint'(f_re) == er, {req, " R4 exact real"}, f_re, er);
    chk(longint'(f_im) == ei, {req, " R4 exact imag"}, f_im, ei);
    chk(longint'(t_re) == (er >>> SH), {req, " R5 truncated real"}, t_re, er >>> SH);
    chk(longint'(t_im) == (ei >>> SH), {req, " R5 truncated imag"}, t_im, ei >>> SH);
  endtask

  task automatic noise();
    a = DW'($urandom); b = DW'($urandom); c = CW'($urandom); d = CW'($urandom);
  endtask

  task automatic wait_slot();
    while (!in_slot) @(negedge clk);
  endtask

  // R1 and R2: reset values, then slot cadence after release.
  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; a = '0; b = '0; c = '0; d = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    chk(t_re == '0 && t_im == '0, "R1 outputs zero in reset", t_re, 0);
    chk(in_slot == 1'b1, "R1 in_slot in reset", in_slot, 1);
    rst_n = 1'b1;
    for (int k = 0; k < 9; k++) begin
      chk(in_slot == (k % 3 == 0), "R2 slot cadence", in_slot, (k % 3 == 0));
      @(negedge clk);
    end
  endtask

  // R3, R4, R5, R6: one capture with off-slot noise, then check timing and hold.
  task automatic t_single(input longint ar, input longint br, input longint cr,
                          input longint dr, input string req);
    longint hr;
    wait_slot();
    a = DW'(ar); b = DW'(br); c = CW'(cr); d = CW'(dr); in_valid = 1'b1;
    @(negedge clk);
    noise(); in_valid = 1'b1;   // R3: off-slot noise with valid high
    chk(out_valid == 1'b0, "R6 no early pulse", out_valid, 0);
    @(negedge clk);
    noise();
    chk(out_valid == 1'b0, "R6 no early pulse", out_valid, 0);
    @(negedge clk);
    noise(); in_valid = 1'b0;
    chk(out_valid == 1'b0, "R6 no early pulse", out_valid, 0);
    @(negedge clk);
    check_result(ar, br, cr, dr, req);
    hr = t_re;
    @(negedge clk);
    chk(out_valid == 1'b0, "R6 single-cycle pulse", out_valid, 0);
    chk(longint'(t_re) == hr, "R7 output held", t_re, hr);
  endtask

  // R7: a slot without capture gives no pulse and no output change.
  task automatic t_skip();
    longint hr, hi;
    wait_slot();
    hr = t_re; hi = f_im;
    noise(); in_valid = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (k == 2) noise();
      chk(out_valid == 1'b0, "R7 no pulse without capture", out_valid, 0);
      chk(longint'(t_re) == hr && longint'(f_im) == hi, "R7 outputs unchanged", t_re, hr);
    end
  endtask

  // R9: captures in three consecutive slots.
  task automatic t_stream();
    longint va[3], vb[3], vc[3], vd[3];
    for (int i = 0; i < 3; i++) begin
      va[i] = longint'($signed(DW'($urandom))); vb[i] = longint'($signed(DW'($urandom)));
      vc[i] = longint'($signed(CW'($urandom))); vd[i] = longint'($signed(CW'($urandom)));
    end
    wait_slot();
    for (int k = 0; k < 12; k++) begin
      if (k >= 4 && (k - 4) % 3 == 0 && (k - 4) / 3 < 3)
        check_result(va[(k-4)/3], vb[(k-4)/3], vc[(k-4)/3], vd[(k-4)/3], "R9 stream");
      else if (k >= 1)
        chk(out_valid == 1'b0, "R9 pulse spacing", out_valid, 0);
      if (k % 3 == 0 && k < 9) begin
        a = DW'(va[k/3]); b = DW'(vb[k/3]); c = CW'(vc[k/3]); d = CW'(vd[k/3]);
        in_valid = 1'b1;
      end else begin
        noise(); in_valid = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    longint mn_a, mn_c;
    mn_a = -(longint'(1) <<< (DW - 1));
    mn_c = -(longint'(1) <<< (CW - 1));
    t_reset();
    t_single(100, -37, 45, 12, "R4 mixed signs");
    t_single(-1, -1, 1, 1, "R5 small negative");
    t_single(2047, 2047, 511, 511, "R4 positive full scale");
    t_skip();
    t_single(mn_a, mn_a, mn_c, mn_c, "R8 negative full scale");
    t_single(mn_a, 2047, 511, mn_c, "R8 mixed full scale");
    t_stream();
    t_skip();
    t_stream();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule